// File: doc/BRIEF.md
# Uncorrectable Error Header Log with Pending-Record Queue

This block keeps the logging state for the uncorrectable error currently presented to software: a pointer to the status bit of that error, a four-dword header log and a four-dword prefix log. When multiple-header recording is switched on, errors that arrive while the logged error is still unacknowledged are held in a small first-in first-out queue of pending records instead of overwriting the log.

The signaling logic hands in one record per request: a one-hot status bit, the raw header and prefix dwords, and two flags that say whether the header is valid and whether a prefix came with it. The status register itself lives outside the block. The block reads that register's current value, and software writes to it are announced with a one-cycle strobe. When software clears the bit of the logged error, the oldest queued record moves into the log. On each such write the block also asks the status register owner to set again the bits of every record still waiting, so that a clear cannot drop a pending error.

Top module: `elog_hdr_queue`

## Requirements
- R1: `first_err_ptr` holds the index of the lowest set bit of the status word of the record in the log. Encoding: bit k maps to value k.
- R2: A record request is queued, leaving the log untouched, when multiple-header recording is on and `uncor_status[first_err_ptr]` is 1. In every other case the record loads the log in the cycle after the request.
- R3: A request that should be queued while the queue holds `QDEPTH` records is dropped, and `log_overflow` is high for exactly the one cycle after that request.
- R4: Queued records reach the log oldest first.
- R5: Header dword j is taken from `rec_header[32j+31:32j]` and stored at `hdr_log[32j+31:32j]` with its bytes reversed: input bits [7:0] land on [31:24]. The header log is all zero when the loaded record's header-valid flag is 0.
- R6: The prefix log is filled with the same byte reversal, and `pfx_present` is set, only if the loaded record carries a prefix and `pfx_support_en` is 1 when the record is loaded. Otherwise both are zero.
- R7: On a status write that leaves `uncor_status[first_err_ptr]` at 0, with recording on and the queue not empty, the block pulses `reassert_vld` one cycle later. `reassert_mask` then has one bit set for each record queued before the write, including the record being loaded. The oldest record is loaded into the log in the same cycle.
- R8: On a status write that leaves the pointed bit at 0 in any other case, the pointer, `pfx_present` and both logs return to zero.
- R9: On a status write that leaves the pointed bit at 1, recording on gives the R7 reassert pulse with no change to the log. Recording off empties the queue and gives no pulse.
- R10: `mhr_capable` is 1 exactly when `QDEPTH` is greater than 0. With `QDEPTH` of 0, `mhr_en` has no effect.
- R11: After reset, all outputs except `mhr_capable` are zero and the queue is empty.
- R12: The queue never holds more than `QDEPTH` records, and `QDEPTH` is at most 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rec_valid | input | 1 | Record request strobe |
| rec_status | input | 32 | One-hot uncorrectable status bit of the record |
| rec_header | input | 128 | Raw header dwords, dword 0 in the low bits |
| rec_prefix | input | 128 | Raw prefix dwords, dword 0 in the low bits |
| rec_hdr_vld | input | 1 | Header dwords are meaningful |
| rec_pfx_flag | input | 1 | Record carries a prefix |
| sw_wr | input | 1 | Software has written the status register this cycle |
| uncor_status | input | 32 | Current value of the uncorrectable status register |
| mhr_en | input | 1 | Multiple-header recording enable |
| pfx_support_en | input | 1 | End-to-end prefix support enable |
| first_err_ptr | output | 5 | Bit index of the logged error |
| hdr_log | output | 128 | Header log, bytes reversed per dword |
| pfx_log | output | 128 | Prefix log, bytes reversed per dword |
| pfx_present | output | 1 | Prefix log holds a valid prefix |
| log_overflow | output | 1 | One-cycle pulse: a record was dropped |
| reassert_vld | output | 1 | One-cycle pulse: set `reassert_mask` bits again |
| reassert_mask | output | 32 | Status bits of queued records |
| mhr_capable | output | 1 | Multiple-header recording can be offered |

## Verification
The assertions take for granted that a record request and a status write never fall in the same cycle. They also take for granted that every request carries exactly one status bit, and that `uncor_status` already shows the written value in the cycle of `sw_wr`. The stimulus keeps to this by issuing one operation per row, each one a one-hot request or a write, never both. The bench also keeps its own copy of the status register: it sets a bit on every request, clears the written bit before the strobe, and after each write ORs in the expected reassert mask, as the status register owner would.

// File: rtl/elog_pkg.sv
// Shared widths, record type and helpers for the error header log queue.
// Assumes 32-bit dwords and a four-dword header and prefix.
package elog_pkg;
    parameter int unsigned STAT_W = 32;
    parameter int unsigned IDX_W  = $clog2(STAT_W);
    parameter int unsigned DW     = 32;
    parameter int unsigned NDW    = 4;
    parameter int unsigned LOG_W  = DW * NDW;
    parameter int unsigned NBYTE  = DW / 8;

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic             hdr_vld;
        logic             pfx_flag;
        logic [LOG_W-1:0] hdr;
        logic [LOG_W-1:0] pfx;
    } elog_rec_t;

    // Index of the lowest set bit (zero when no bit is set).
    function automatic logic [IDX_W-1:0] low_bit_idx(input logic [STAT_W-1:0] v);
        logic [IDX_W-1:0] r;
        r = '0;
        for (int i = STAT_W - 1; i >= 0; i--) begin
            if (v[i]) r = IDX_W'(i);
        end
        return r;
    endfunction

    // Reverse the byte order inside every dword of a log word.
    function automatic logic [LOG_W-1:0] swap_dwords(input logic [LOG_W-1:0] v);
        logic [LOG_W-1:0] r;
        for (int d = 0; d < int'(NDW); d++) begin
            for (int b = 0; b < int'(NBYTE); b++) begin
                r[d*DW + b*8 +: 8] = v[d*DW + (NBYTE-1-b)*8 +: 8];
            end
        end
        return r;
    endfunction
endpackage

// File: rtl/elog_queue.sv
// Pending-record FIFO built as a shift register: the head is always slot 0.
// Assumes push and pop never coincide and push is never asked when full.
module elog_queue
    import elog_pkg::*;
#(
    parameter int unsigned DEPTH = 4
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  elog_rec_t         push_rec,
    input  logic              pop,
    input  logic              flush,
    output elog_rec_t         head_rec,
    output logic              full,
    output logic              empty,
    output logic [STAT_W-1:0] pending_mask
);
    localparam int unsigned CW = $clog2(DEPTH + 1);

    elog_rec_t       slot [DEPTH];
    logic [CW-1:0]   count;

    // Occupancy: flush wins, then push or pop.
    always_ff @(posedge clk) begin
        if (!rst_n)     count <= '0;
        else if (flush) count <= '0;
        else if (push)  count <= count + CW'(1);
        else if (pop)   count <= count - CW'(1);
    end

    // Slot data: write at the tail, shift towards the head on pop.
    for (genvar g = 0; g < int'(DEPTH); g++) begin : g_slot
        if (g < int'(DEPTH) - 1) begin : g_mid
            always_ff @(posedge clk) begin
                if (push && count == CW'(g)) slot[g] <= push_rec;
                else if (pop)                slot[g] <= slot[g+1];
            end
        end else begin : g_last
            always_ff @(posedge clk) begin
                if (push && count == CW'(g)) slot[g] <= push_rec;
            end
        end
    end

    assign head_rec = slot[0];
    assign full     = (count == CW'(DEPTH));
    assign empty    = (count == '0);

    // Status bits of every occupied slot.
    always_comb begin
        pending_mask = '0;
        for (int i = 0; i < int'(DEPTH); i++) begin
            if (CW'(i) < count) pending_mask[slot[i].idx] = 1'b1;
        end
    end

    a_r12_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    a_r3_no_push_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    a_r4_first_in_is_head: assert property (@(posedge clk) disable iff (!rst_n)
        (push && empty && !flush) |=> head_rec == $past(push_rec));
endmodule

// File: rtl/elog_regs.sv
// Log register set: first-error pointer, header log, prefix log, prefix flag.
// Assumes load and clear are never raised together; load wins if they are.
module elog_regs
    import elog_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  elog_rec_t        ld_rec,
    input  logic             pfx_support_en,
    input  logic             clear,
    output logic [IDX_W-1:0] fep,
    output logic [LOG_W-1:0] hdr_log,
    output logic [LOG_W-1:0] pfx_log,
    output logic             pfx_present
);
    // Load a record or wipe the log.
    always_ff @(posedge clk) begin
        if (!rst_n || (clear && !load)) begin
            fep         <= '0;
            hdr_log     <= '0;
            pfx_log     <= '0;
            pfx_present <= 1'b0;
        end else if (load) begin
            fep     <= ld_rec.idx;
            hdr_log <= ld_rec.hdr_vld ? swap_dwords(ld_rec.hdr) : '0;
            if (ld_rec.pfx_flag && pfx_support_en) begin
                pfx_log     <= swap_dwords(ld_rec.pfx);
                pfx_present <= 1'b1;
            end else begin
                pfx_log     <= '0;
                pfx_present <= 1'b0;
            end
        end
    end

    a_r8_clear_wipes: assert property (@(posedge clk) disable iff (!rst_n)
        (clear && !load) |=> (fep == '0 && hdr_log == '0 && pfx_log == '0 && !pfx_present));
    a_r6_absent_prefix_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !pfx_present |-> pfx_log == '0);
endmodule

// File: rtl/elog_hdr_queue.sv
// Top: decides per request whether to log or queue, and per status write
// whether to advance, wipe, reassert or flush.
// Assumes rec_valid and sw_wr are exclusive, rec_status is one-hot, and
// uncor_status already reflects a write in the cycle of sw_wr.
module elog_hdr_queue
    import elog_pkg::*;
#(
    parameter int unsigned QDEPTH = 4
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rec_valid,
    input  logic [STAT_W-1:0] rec_status,
    input  logic [LOG_W-1:0]  rec_header,
    input  logic [LOG_W-1:0]  rec_prefix,
    input  logic              rec_hdr_vld,
    input  logic              rec_pfx_flag,
    input  logic              sw_wr,
    input  logic [STAT_W-1:0] uncor_status,
    input  logic              mhr_en,
    input  logic              pfx_support_en,
    output logic [IDX_W-1:0]  first_err_ptr,
    output logic [LOG_W-1:0]  hdr_log,
    output logic [LOG_W-1:0]  pfx_log,
    output logic              pfx_present,
    output logic              log_overflow,
    output logic              reassert_vld,
    output logic [STAT_W-1:0] reassert_mask,
    output logic              mhr_capable
);
    localparam bit HAS_Q = (QDEPTH > 0);

    elog_rec_t         in_rec, head_rec, ld_rec;
    logic              mhr_on, ptr_bit, q_full, q_empty;
    logic              queue_it, push, pop, flush, load_new, clr_first, clear_log, reassert_now;
    logic [STAT_W-1:0] pend_mask;

    // Incoming record as stored and loaded.
    always_comb begin
        in_rec.idx      = low_bit_idx(rec_status);
        in_rec.hdr_vld  = rec_hdr_vld;
        in_rec.pfx_flag = rec_pfx_flag;
        in_rec.hdr      = rec_header;
        in_rec.pfx      = rec_prefix;
    end

    // Request and write decisions.
    always_comb begin
        mhr_on       = mhr_en && HAS_Q;
        ptr_bit      = uncor_status[first_err_ptr];
        queue_it     = rec_valid && mhr_on && ptr_bit;
        push         = queue_it && !q_full;
        load_new     = rec_valid && !queue_it;
        clr_first    = sw_wr && !ptr_bit;
        pop          = clr_first && mhr_on && !q_empty;
        clear_log    = clr_first && !pop;
        flush        = sw_wr && ptr_bit && !mhr_on;
        reassert_now = sw_wr && mhr_on && !q_empty;
        ld_rec       = load_new ? in_rec : head_rec;
    end

    if (HAS_Q) begin : g_queue
        elog_queue #(.DEPTH(QDEPTH)) u_queue (
            .clk(clk), .rst_n(rst_n), .push(push), .push_rec(in_rec),
            .pop(pop), .flush(flush), .head_rec(head_rec), .full(q_full),
            .empty(q_empty), .pending_mask(pend_mask)
        );
    end else begin : g_noqueue
        assign head_rec  = '0;
        assign q_full    = 1'b1;
        assign q_empty   = 1'b1;
        assign pend_mask = '0;
    end

    elog_regs u_regs (
        .clk(clk), .rst_n(rst_n), .load(load_new || pop), .ld_rec(ld_rec),
        .pfx_support_en(pfx_support_en), .clear(clear_log),
        .fep(first_err_ptr), .hdr_log(hdr_log), .pfx_log(pfx_log),
        .pfx_present(pfx_present)
    );

    // Registered pulses for overflow and status reassertion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            log_overflow  <= 1'b0;
            reassert_vld  <= 1'b0;
            reassert_mask <= '0;
        end else begin
            log_overflow  <= queue_it && q_full;
            reassert_vld  <= reassert_now;
            reassert_mask <= reassert_now ? pend_mask : '0;
        end
    end

    assign mhr_capable = HAS_Q;

    a_r2_exclusive_ops: assert property (@(posedge clk) disable iff (!rst_n)
        !(rec_valid && sw_wr));
    a_r1_onehot_request: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid |-> $countones(rec_status) == 1);
    a_r3_overflow_cause: assert property (@(posedge clk) disable iff (!rst_n)
        log_overflow |-> $past(rec_valid && mhr_en));
    a_r7_reassert_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        reassert_vld |-> reassert_mask != '0);
    a_r9_reassert_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        reassert_vld |-> $past(sw_wr && mhr_en));
endmodule

// File: tb/elog_hdr_queue_tb.sv
`timescale 1ns/100ps
module elog_hdr_queue_tb;
    logic         clk = 1'b0;
    logic         rst_n;
    logic         rec_valid, rec_hdr_vld, rec_pfx_flag, sw_wr, mhr_en, pfx_support_en;
    logic [31:0]  rec_status, uncor_status;
    logic [127:0] rec_header, rec_prefix;
    logic [4:0]   first_err_ptr;
    logic [127:0] hdr_log, pfx_log;
    logic         pfx_present, log_overflow, reassert_vld, mhr_capable;
    logic [31:0]  reassert_mask;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    elog_hdr_queue u_dut (
        .clk(clk), .rst_n(rst_n), .rec_valid(rec_valid), .rec_status(rec_status),
        .rec_header(rec_header), .rec_prefix(rec_prefix), .rec_hdr_vld(rec_hdr_vld),
        .rec_pfx_flag(rec_pfx_flag), .sw_wr(sw_wr), .uncor_status(uncor_status),
        .mhr_en(mhr_en), .pfx_support_en(pfx_support_en), .first_err_ptr(first_err_ptr),
        .hdr_log(hdr_log), .pfx_log(pfx_log), .pfx_present(pfx_present),
        .log_overflow(log_overflow), .reassert_vld(reassert_vld),
        .reassert_mask(reassert_mask), .mhr_capable(mhr_capable)
    );

    typedef struct packed {
        logic        op;      // 0 record request, 1 status write clearing bidx
        logic [4:0]  bidx;
        logic        hv, pf, mhr, pfe;
        logic [4:0]  efep;
        logic        eovf;
        logic [31:0] emask;
        logic [7:0]  ehk;     // record whose header is logged, FF = zero
        logic [7:0]  epk;     // record whose prefix is logged, FF = none
    } row_t;

    localparam int NROW = 18;
    localparam row_t TBL [NROW] = '{
        '{1'b0, 5'd4,  1'b1,1'b1,1'b1,1'b1, 5'd4,  1'b0, 32'h0,    8'd4,  8'd4 },
        '{1'b0, 5'd7,  1'b1,1'b0,1'b1,1'b1, 5'd4,  1'b0, 32'h0,    8'd4,  8'd4 },
        '{1'b0, 5'd9,  1'b0,1'b0,1'b1,1'b1, 5'd4,  1'b0, 32'h0,    8'd4,  8'd4 },
        '{1'b0, 5'd12, 1'b1,1'b1,1'b1,1'b1, 5'd4,  1'b0, 32'h0,    8'd4,  8'd4 },
        '{1'b0, 5'd14, 1'b1,1'b0,1'b1,1'b1, 5'd4,  1'b0, 32'h0,    8'd4,  8'd4 },
        '{1'b0, 5'd20, 1'b1,1'b0,1'b1,1'b1, 5'd4,  1'b1, 32'h0,    8'd4,  8'd4 },
        '{1'b1, 5'd20, 1'b0,1'b0,1'b1,1'b1, 5'd4,  1'b0, 32'h5280, 8'd4,  8'd4 },
        '{1'b1, 5'd4,  1'b0,1'b0,1'b1,1'b1, 5'd7,  1'b0, 32'h5280, 8'd7,  8'hFF},
        '{1'b1, 5'd7,  1'b0,1'b0,1'b1,1'b1, 5'd9,  1'b0, 32'h5200, 8'hFF, 8'hFF},
        '{1'b1, 5'd9,  1'b0,1'b0,1'b1,1'b1, 5'd12, 1'b0, 32'h5000, 8'd12, 8'd12},
        '{1'b1, 5'd12, 1'b0,1'b0,1'b1,1'b1, 5'd14, 1'b0, 32'h4000, 8'd14, 8'hFF},
        '{1'b1, 5'd14, 1'b0,1'b0,1'b1,1'b1, 5'd0,  1'b0, 32'h0,    8'hFF, 8'hFF},
        '{1'b0, 5'd3,  1'b1,1'b1,1'b0,1'b0, 5'd3,  1'b0, 32'h0,    8'd3,  8'hFF},
        '{1'b0, 5'd5,  1'b1,1'b1,1'b0,1'b1, 5'd5,  1'b0, 32'h0,    8'd5,  8'd5 },
        '{1'b0, 5'd6,  1'b1,1'b1,1'b1,1'b1, 5'd5,  1'b0, 32'h0,    8'd5,  8'd5 },
        '{1'b0, 5'd8,  1'b1,1'b1,1'b1,1'b1, 5'd5,  1'b0, 32'h0,    8'd5,  8'd5 },
        '{1'b1, 5'd3,  1'b0,1'b0,1'b0,1'b1, 5'd5,  1'b0, 32'h0,    8'd5,  8'd5 },
        '{1'b1, 5'd5,  1'b0,1'b0,1'b1,1'b1, 5'd0,  1'b0, 32'h0,    8'hFF, 8'hFF}
    };

    // Raw header of record k: dword j = {j, 5A, k, C3}.
    function automatic logic [127:0] raw_hdr(input logic [7:0] k);
        for (int j = 0; j < 4; j++) raw_hdr[j*32 +: 32] = {8'(j), 8'h5A, k, 8'hC3};
    endfunction
    function automatic logic [127:0] raw_pfx(input logic [7:0] k);
        for (int j = 0; j < 4; j++) raw_pfx[j*32 +: 32] = {8'h77, 8'h3C, k, 8'(8'hE0 | j)};
    endfunction
    // Expected logged forms, bytes reversed per dword (R5, R6).
    function automatic logic [127:0] exp_hdr(input logic [7:0] k);
        if (k == 8'hFF) return '0;
        for (int j = 0; j < 4; j++) exp_hdr[j*32 +: 32] = {8'hC3, k, 8'h5A, 8'(j)};
    endfunction
    function automatic logic [127:0] exp_pfx(input logic [7:0] k);
        if (k == 8'hFF) return '0;
        for (int j = 0; j < 4; j++) exp_pfx[j*32 +: 32] = {8'(8'hE0 | j), k, 8'h3C, 8'h77};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        rec_valid = 1'b0; sw_wr = 1'b0; rec_status = '0;
        rec_header = '0; rec_prefix = '0; rec_hdr_vld = 1'b0; rec_pfx_flag = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        rst_n = 1'b0; mhr_en = 1'b1; pfx_support_en = 1'b1; uncor_status = '0;
        idle_inputs();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11 and R10: state straight out of reset.
        chk(first_err_ptr == 0, "R11 pointer after reset", 128'(first_err_ptr), 0);
        chk(hdr_log == 0 && pfx_log == 0 && !pfx_present, "R11 logs after reset",
            hdr_log | pfx_log, 0);
        chk(!log_overflow && !reassert_vld && reassert_mask == 0, "R11 pulses after reset",
            128'({log_overflow, reassert_vld, reassert_mask}), 0);
        chk(mhr_capable == 1'b1, "R10 capability with nonzero depth", 128'(mhr_capable), 1);
        rst_n = 1'b1;
        @(negedge clk);

        for (int r = 0; r < NROW; r++) begin
            row_t t;
            t = TBL[r];
            mhr_en = t.mhr; pfx_support_en = t.pfe;
            if (!t.op) begin
                rec_valid = 1'b1; rec_status = 32'(1) << t.bidx;
                rec_header = raw_hdr(8'(t.bidx)); rec_prefix = raw_pfx(8'(t.bidx));
                rec_hdr_vld = t.hv; rec_pfx_flag = t.pf;
            end else begin
                uncor_status = uncor_status & ~(32'(1) << t.bidx);
                sw_wr = 1'b1;
            end
            @(negedge clk);
            idle_inputs();
            if (!t.op) uncor_status = uncor_status | (32'(1) << t.bidx);
            chk(first_err_ptr == t.efep, $sformatf("R1 R2 R4 R8 pointer row %0d", r),
                128'(first_err_ptr), 128'(t.efep));
            chk(log_overflow == t.eovf, $sformatf("R3 R12 overflow row %0d", r),
                128'(log_overflow), 128'(t.eovf));
            chk(reassert_vld == (t.emask != 0) && reassert_mask == t.emask,
                $sformatf("R7 R9 reassert row %0d", r),
                128'({reassert_vld, reassert_mask}), 128'({t.emask != 0, t.emask}));
            chk(hdr_log == exp_hdr(t.ehk), $sformatf("R5 header row %0d", r),
                hdr_log, exp_hdr(t.ehk));
            chk(pfx_log == exp_pfx(t.epk) && pfx_present == (t.epk != 8'hFF),
                $sformatf("R6 prefix row %0d", r), pfx_log, exp_pfx(t.epk));
            uncor_status = uncor_status | t.emask;
        end

        // R11: reset in mid-run with a loaded log returns everything to zero.
        rec_valid = 1'b1; rec_status = 32'h4; rec_header = raw_hdr(8'd2); rec_hdr_vld = 1'b1;
        @(negedge clk);
        idle_inputs();
        chk(first_err_ptr == 5'd2, "R1 pointer before second reset", 128'(first_err_ptr), 2);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk(first_err_ptr == 0 && hdr_log == 0 && !pfx_present, "R11 log after second reset",
            hdr_log, 0);
        finish_run();
    end

    initial begin
        #(200000 * 5);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired act=running exp=finished");
        finish_run();
    end
endmodule